// File: doc/BRIEF.md
# Square-Wave Tone Channel Generator

This block produces the digital sample stream of one square-wave tone voice. An 11-bit period counter advances on an external clock-enable. Each time it overflows, an 8-position duty pointer moves one step through one of four fixed duty patterns. While the pattern bit under the pointer is high, the 4-bit output carries the current envelope volume; otherwise it carries zero. An envelope unit, paced by its own clock-enable, can ramp that volume up or down.

A trigger strobe starts the voice. It reloads the period counter and the envelope, but it leaves the duty pointer where it was, so a voice that is triggered again and again keeps its step frozen. Only dropping the global audio enable returns the pointer to zero, clears the voice and silences the output. The converter-enable flag comes straight from the upper five bits of the volume/envelope control byte. When that converter is off, the voice is stopped.

Top module: `sqr_tone_gen`

## Requirements
- R1: Until the voice has been triggered with its converter enabled, `sample` is 0 and `active` is 0, whatever the other inputs do.
- R2: `dac_on` is 1 exactly when bits 7..3 of `env_ctrl` are not all zero. The envelope never changes it.
- R3: A trigger while `dac_on` is 1 makes `active` 1 in the next cycle. A cycle with `dac_on` at 0 makes `active` 0 in the next cycle, even if a trigger is present in that cycle.
- R4: While active, each `tick` without a trigger increments the period counter. When a tick finds the counter at 2047, the counter reloads `period` and the duty pointer advances by one, wrapping from 7 to 0. Period 2046 therefore gives one step every 2 ticks, and period 2045 gives one step every 3 ticks.
- R5: The pattern for `duty_sel` 0, 1, 2 and 3 is 8'b00000001, 8'b10000001, 8'b10000111 and 8'b01111110. Pointer position p reads bit 7-p, so position 0 reads the MSB.
- R6: A trigger reloads the period counter from `period` and does not move the duty pointer. If triggers arrive more often than one step period, the pointer never advances.
- R7: While `apu_en` is 0, the duty pointer, period counter, envelope and `active` all return to zero. The next trigger after re-enabling starts at pointer position 0.
- R8: A trigger loads the envelope volume from `env_ctrl[7:4]`. While active, `sample` equals that volume when the pattern bit is 1 and equals 0 when it is 0.
- R9: The envelope period comes from `env_ctrl[2:0]` and the direction from `env_ctrl[3]` (1 = up), both captured at trigger. With a period of N>0, the volume steps once every N `env_tick` pulses while active. It saturates at 15 and at 0. A period of 0 holds the volume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apu_en | input | 1 | Global audio enable; 0 clears the voice and pointer |
| tick | input | 1 | Period counter clock-enable |
| env_tick | input | 1 | Envelope clock-enable |
| trigger | input | 1 | Start/restart strobe |
| duty_sel | input | 2 | Duty pattern select |
| period | input | 11 | Period counter reload value |
| env_ctrl | input | 8 | Initial volume [7:4], direction [3], envelope period [2:0] |
| sample | output | 4 | Digital output sample |
| active | output | 1 | Voice running |
| dac_on | output | 1 | Converter enabled |

## Verification
The properties assume that `trigger`, `tick` and `env_tick` are single-cycle pulses sampled at the rising edge. They also assume that `apu_en` and `env_ctrl` are steady across each edge. The stimulus meets this by changing every input only at the falling edge. It holds the control inputs through each cycle and toggles the strobes one cycle at a time. The checks also take for granted that the pointer and volume are observed only through `sample`. For that reason the stimulus chooses patterns and volumes in which every step and every envelope change shows up at the output.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
    localparam int STEP_W = 3;
    localparam int STEPS  = 1 << STEP_W;

    typedef enum logic [1:0] {
        DUTY_EIGHTH  = 2'd0,
        DUTY_QUARTER = 2'd1,
        DUTY_HALF    = 2'd2,
        DUTY_WIDE    = 2'd3
    } duty_e;

    function automatic logic [STEPS-1:0] duty_pattern(input duty_e sel);
        case (sel)
            DUTY_EIGHTH:  return 8'b0000_0001;
            DUTY_QUARTER: return 8'b1000_0001;
            DUTY_HALF:    return 8'b1000_0111;
            default:      return 8'b0111_1110;
        endcase
    endfunction
endpackage

// File: rtl/sqr_period_timer.sv
module sqr_period_timer #(
    parameter int PER_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             load,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = run && tick && !load && (tmr_q.cnt == CNT_MAX);
        if (clr) begin
            tmr_d.cnt = '0;
        end else if (load) begin
            tmr_d.cnt = period;
        end else if (run && tick) begin
            tmr_d.cnt = wrap ? period : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign step = wrap && !clr;
endmodule

// File: rtl/sqr_duty_seq.sv
module sqr_duty_seq
    import sqr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [1:0]        duty_sel,
    output logic [STEP_W-1:0] pos,
    output logic              level
);
    typedef struct packed {
        logic [STEP_W-1:0] pos;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [STEPS-1:0] pat;

    always_comb begin
        seq_d = seq_q;
        if (clr)      seq_d.pos = '0;
        else if (adv) seq_d.pos = seq_q.pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        pat   = duty_pattern(duty_e'(duty_sel));
        level = pat[(STEPS-1) - int'(seq_q.pos)];
    end

    assign pos = seq_q.pos;
endmodule

// File: rtl/sqr_envelope.sv
module sqr_envelope #(
    parameter int VOL_W  = 4,
    parameter int EPER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              run,
    input  logic              env_tick,
    input  logic [VOL_W-1:0]  init_vol,
    input  logic              dir_up,
    input  logic [EPER_W-1:0] env_per,
    output logic [VOL_W-1:0]  vol
);
    localparam logic [VOL_W-1:0] VOL_MAX = '1;

    typedef struct packed {
        logic [VOL_W-1:0]  vol;
        logic              up;
        logic [EPER_W-1:0] per;
        logic [EPER_W-1:0] cnt;
    } env_t;

    env_t env_d, env_q;

    always_comb begin
        env_d = env_q;
        if (clr) begin
            env_d = '0;
        end else if (load) begin
            env_d.vol = init_vol;
            env_d.up  = dir_up;
            env_d.per = env_per;
            env_d.cnt = env_per;
        end else if (run && env_tick && (env_q.per != '0)) begin
            if (env_q.cnt <= 1) begin
                env_d.cnt = env_q.per;
                if (env_q.up && env_q.vol != VOL_MAX)
                    env_d.vol = env_q.vol + 1'b1;
                else if (!env_q.up && env_q.vol != '0)
                    env_d.vol = env_q.vol - 1'b1;
            end else begin
                env_d.cnt = env_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) env_q <= '0;
        else        env_q <= env_d;
    end

    assign vol = env_q.vol;
endmodule

// File: rtl/sqr_tone_gen.sv
module sqr_tone_gen
    import sqr_pkg::*;
#(
    parameter int PER_W  = 11,
    parameter int VOL_W  = 4,
    parameter int EPER_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          apu_en,
    input  logic                          tick,
    input  logic                          env_tick,
    input  logic                          trigger,
    input  logic [1:0]                    duty_sel,
    input  logic [PER_W-1:0]              period,
    input  logic [VOL_W+EPER_W:0]         env_ctrl,
    output logic [VOL_W-1:0]              sample,
    output logic                          active,
    output logic                          dac_on
);
    localparam int CTRL_W = VOL_W + EPER_W + 1;
    localparam int DIR_B  = EPER_W;

    typedef struct packed {
        logic active;
    } ch_t;

    ch_t ch_d, ch_q;
    logic clr, load, step, level;
    logic [STEP_W-1:0] duty_pos;
    logic [VOL_W-1:0]  env_vol;

    assign clr    = !apu_en;
    assign load   = apu_en && trigger;
    assign dac_on = |env_ctrl[CTRL_W-1:DIR_B];

    always_comb begin
        ch_d = ch_q;
        if (clr)       ch_d.active = 1'b0;
        else if (load) ch_d.active = dac_on;
        else           ch_d.active = ch_q.active && dac_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    sqr_period_timer #(.PER_W(PER_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(ch_q.active),
        .load(load), .tick(tick), .period(period), .step(step)
    );

    sqr_duty_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(step),
        .duty_sel(duty_sel), .pos(duty_pos), .level(level)
    );

    sqr_envelope #(.VOL_W(VOL_W), .EPER_W(EPER_W)) u_env (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load),
        .run(ch_q.active), .env_tick(env_tick),
        .init_vol(env_ctrl[CTRL_W-1:CTRL_W-VOL_W]),
        .dir_up(env_ctrl[DIR_B]), .env_per(env_ctrl[EPER_W-1:0]),
        .vol(env_vol)
    );

    assign active = ch_q.active;
    assign sample = (ch_q.active && level) ? env_vol : '0;
endmodule

// File: rtl/sqr_tone_chk.sv
module sqr_tone_chk #(
    parameter int VOL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             apu_en,
    input logic             trigger,
    input logic             tick,
    input logic             env_tick,
    input logic             dac_on,
    input logic             active,
    input logic [VOL_W-1:0] sample,
    input logic [VOL_W-1:0] vol,
    input logic [2:0]       duty_pos
);
    // R1
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sample == '0);

    // R3
    dac_off_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_on |=> !active);

    // R3
    trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apu_en && trigger && dac_on) |=> active);

    // R7
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apu_en |=> (!active && duty_pos == 3'd0));

    // R6
    trig_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apu_en && trigger) |=> duty_pos == $past(duty_pos));

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apu_en && !tick) |=> $stable(duty_pos));

    // R9
    env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apu_en && !env_tick && !trigger) |=> $stable(vol));

    // R8
    sample_is_vol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample != '0 |-> sample == vol);
endmodule

bind sqr_tone_gen sqr_tone_chk #(.VOL_W(VOL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .apu_en(apu_en), .trigger(trigger),
    .tick(tick), .env_tick(env_tick), .dac_on(dac_on), .active(active),
    .sample(sample), .vol(env_vol), .duty_pos(duty_pos)
);

// File: tb/sqr_tone_gen_tb.sv
module sqr_tone_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apu_en = 1'b0, tick = 1'b0, env_tick = 1'b0, trigger = 1'b0;
    logic [1:0]  duty_sel = 2'd0;
    logic [10:0] period = 11'd0;
    logic [7:0]  env_ctrl = 8'd0;
    logic [3:0]  sample;
    logic        active, dac_on;

    always #2 clk = ~clk;

    sqr_tone_gen u_dut (
        .clk(clk), .rst_n(rst_n), .apu_en(apu_en), .tick(tick),
        .env_tick(env_tick), .trigger(trigger), .duty_sel(duty_sel),
        .period(period), .env_ctrl(env_ctrl), .sample(sample),
        .active(active), .dac_on(dac_on)
    );

    int checks = 0;
    int errors = 0;
    logic [3:0] q_smp[$];
    logic       q_act[$];
    logic       q_dac[$];
    string      q_req[$];

    // settings applied by the next cycle
    logic        b_apu = 1'b1;
    logic [1:0]  b_duty = 2'd0;
    logic [10:0] b_per = 11'd0;
    logic [7:0]  b_ctrl = 8'd0;
    string       cur_req = "R1";

    // reference state, kept from the requirement text
    int  m_pos = 0, m_cnt = 0, m_vol = 0, m_eper = 0, m_ecnt = 0;
    bit  m_up = 0, m_act = 0;

    function automatic logic [7:0] pat_of(input logic [1:0] d);
        // R5 patterns
        case (d)
            2'd0: return 8'b00000001;
            2'd1: return 8'b10000001;
            2'd2: return 8'b10000111;
            default: return 8'b01111110;
        endcase
    endfunction

    task automatic cyc(input bit trg, input bit tk, input bit etk);
        bit dac;
        logic [7:0] p;
        logic [3:0] es;
        @(negedge clk);
        apu_en = b_apu; duty_sel = b_duty; period = b_per; env_ctrl = b_ctrl;
        trigger = trg; tick = tk; env_tick = etk;
        dac = (b_ctrl[7:3] != 5'd0);
        if (!b_apu) begin
            m_pos = 0; m_cnt = 0; m_vol = 0; m_eper = 0; m_ecnt = 0; m_up = 0; m_act = 0;
        end else if (trg) begin
            m_cnt = b_per; m_vol = b_ctrl[7:4]; m_up = b_ctrl[3];
            m_eper = b_ctrl[2:0]; m_ecnt = m_eper; m_act = dac;
        end else begin
            if (m_act && tk) begin
                if (m_cnt == 2047) begin m_cnt = b_per; m_pos = (m_pos + 1) % 8; end
                else m_cnt = m_cnt + 1;
            end
            if (m_act && etk && m_eper != 0) begin
                if (m_ecnt <= 1) begin
                    m_ecnt = m_eper;
                    if (m_up && m_vol < 15) m_vol = m_vol + 1;
                    else if (!m_up && m_vol > 0) m_vol = m_vol - 1;
                end else m_ecnt = m_ecnt - 1;
            end
            m_act = m_act && dac;
        end
        p  = pat_of(b_duty);
        es = (m_act && p[7 - m_pos]) ? 4'(m_vol) : 4'd0;
        q_smp.push_back(es); q_act.push_back(m_act); q_dac.push_back(dac);
        q_req.push_back(cur_req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_smp.size() > 0) begin
                logic [3:0] es; logic ea, ed; string r;
                es = q_smp.pop_front(); ea = q_act.pop_front();
                ed = q_dac.pop_front(); r = q_req.pop_front();
                checks++;
                if (sample !== es || active !== ea || dac_on !== ed) begin
                    errors++;
                    $display("FAIL %s: sample/active/dac = %h/%b/%b expected %h/%b/%b",
                             r, sample, active, dac_on, es, ea, ed);
                end
            end
        end
    end

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        checks++;
        if (sample !== 4'd0 || active !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset sample/active %h/%b expected 0/0", sample, active);
        end
        rst_n = 1'b1;

        // R1 / R2: converter on, no trigger yet, ticks running
        cur_req = "R1"; b_ctrl = 8'hF0; b_duty = 2'd3; b_per = 11'd2046;
        for (int i = 0; i < 10; i++) cyc(0, 1, 1);
        cur_req = "R2";
        b_ctrl = 8'h08; cyc(0, 0, 0);
        b_ctrl = 8'h07; cyc(0, 0, 0);
        b_ctrl = 8'h00; cyc(0, 0, 0);

        // R4 / R5 / R8: each duty with steady volume
        for (int d = 0; d < 4; d++) begin
            cur_req = (d % 2 == 0) ? "R5" : "R4";
            b_duty = 2'(d); b_ctrl = 8'hA0; b_per = 11'd2046;
            cyc(1, 0, 0);
            for (int i = 0; i < 20; i++) cyc(0, 1, 0);
        end
        cur_req = "R4"; b_per = 11'd2045; b_duty = 2'd2;
        cyc(1, 0, 0);
        for (int i = 0; i < 30; i++) cyc(0, (i % 2) == 0, 0);

        // R8: new volume on trigger
        cur_req = "R8"; b_ctrl = 8'h50; b_duty = 2'd3;
        cyc(1, 0, 0);
        for (int i = 0; i < 12; i++) cyc(0, 1, 0);

        // R6: retrigger every other cycle freezes the pointer
        cur_req = "R6"; b_per = 11'd2046;
        for (int i = 0; i < 24; i++) cyc((i % 2) == 0, 1, 0);
        cyc(1, 1, 0);
        for (int i = 0; i < 8; i++) cyc(0, 1, 0);

        // R3: converter off stops, trigger with it off does not start
        cur_req = "R3"; b_ctrl = 8'h07; cyc(0, 1, 0);
        cyc(1, 1, 0); cyc(0, 1, 0);
        b_ctrl = 8'hF0; cyc(0, 1, 0);
        cyc(1, 1, 0); cyc(0, 1, 0);
        b_ctrl = 8'h00; cyc(1, 0, 0); cyc(0, 0, 0);

        // R7: power cycle returns pointer to 0
        cur_req = "R7"; b_ctrl = 8'hC0; b_duty = 2'd0;
        cyc(1, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0);
        b_apu = 1'b0; cyc(0, 1, 1); cyc(1, 1, 1);
        b_apu = 1'b1; cyc(1, 0, 0);
        for (int i = 0; i < 20; i++) cyc(0, 1, 0);

        // R9: envelope up to saturation, down with period 2, period 0 holds
        cur_req = "R9"; b_duty = 2'd3; b_ctrl = 8'h39;
        cyc(1, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 1);
        b_ctrl = 8'h42; cyc(1, 0, 0);
        for (int i = 0; i < 14; i++) cyc(0, 0, 1);
        b_ctrl = 8'h58; cyc(1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1);
        b_ctrl = 8'hEB; cyc(1, 0, 0);
        for (int i = 0; i < 12; i++) cyc(0, 1, 1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule